// File: doc/BRIEF.md
# Dual-Bank Byte-Lane Memory Responder

This block sits on the slave side of a 16-bit multiplexed address/data bus and behaves as a window of memory. In the first bus state an address strobe marks the lines as carrying an address. The responder captures the low sixteen bits from the shared lines and the top four bits from a separate group. It keeps that address, together with the high-byte enable and the memory/IO flag, until the next strobe.

Storage is split into two byte-wide banks. The even bank serves the low byte lane and the odd bank serves the high byte lane. Both banks are indexed by the captured address with bit 0 dropped, taken relative to the window base. The pair of high-byte-enable and address bit 0 selects one of four cases: a full word, the high byte alone, the low byte alone, or no access.

The responder answers only memory cycles whose address lies inside its window. It writes selected lanes while the write strobe is low. It drives read data on selected lanes, with a per-lane output enable, while the read strobe is low. It pulls its ready output low for a fixed number of wait cycles at the start of each access.

Top module: `membus_responder`

## Requirements
- R1: The address, high-byte enable and memory/IO flag are captured at each clock edge where `ale` is high. They stay unchanged at every edge where `ale` is low.
- R2: The low lane `ad_in[7:0]`/`ad_out[7:0]` maps to the even bank and the high lane `[15:8]` maps to the odd bank. Both are indexed by (address − `BASE_ADDR`) shifted right by one.
- R3: `bhe_n`=0 with address bit 0 = 0 reads or writes both lanes, so the whole 16-bit word.
- R4: `bhe_n`=0 with address bit 0 = 1 touches only the high lane. `ad_oe` = 2'b10 on a read.
- R5: `bhe_n`=1 with address bit 0 = 0 touches only the low lane, and `ad_oe` = 2'b01 on a read. `bhe_n`=1 with address bit 0 = 1 touches neither lane: no write, and `ad_oe` = 2'b00.
- R6: `ad_oe` bit g is set at the clock edge after `rd_n` is sampled low on a selected lane of an accepted cycle. It clears at the edge after `rd_n` returns high. `ad_out` carries the stored byte on each enabled lane and zero on a disabled lane.
- R7: During a byte write, the unselected bank keeps its previous contents.
- R8: A cycle whose address is below `BASE_ADDR` or at or above `BASE_ADDR`+`WIN_BYTES` writes nothing, drives nothing and leaves `ready` high.
- R9: A cycle with `mio`=0 (I/O) writes nothing, drives nothing and leaves `ready` high.
- R10: At the first edge where an accepted cycle has `rd_n` or `wr_n` low, `ready` goes low. It stays low for exactly `WAITS` clock periods, then returns high. With `WAITS`=0, `ready` never drops.
- R11: After a synchronous reset, `ready` is 1, `ad_oe` is 2'b00 and `ad_out` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address strobe; high while the bus carries an address |
| ad_in | input | 16 | Shared address/data lines as seen by the responder |
| a_hi | input | 4 | Upper address bits 19..16 |
| bhe_n | input | 1 | High byte enable, active low |
| mio | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| ad_out | output | 16 | Read data toward the bus |
| ad_oe | output | 2 | Per-lane drive enable: bit 0 low lane, bit 1 high lane |
| ready | output | 1 | Low while wait cycles are inserted |

## Verification
The main instance is built with a 512-byte window based at 0x00400 and two wait states. This puts both window edges, a negative offset that would wrap into the top of the bank, and a multi-cycle ready pulse within a few bus cycles. A second instance shares all inputs and is built with zero wait states. It shows that the degenerate count leaves `ready` permanently high while the same traffic runs. Byte writes on each lane are followed by word reads of the same row, which shows directly whether the other bank was disturbed.

// File: rtl/membus_pkg.sv
package membus_pkg;
  localparam int unsigned ADDR_W = 20;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              bhe_n;
    logic              mio;
  } bus_tag_t;

  // {high lane, low lane} selection from the byte-enable pair
  function automatic logic [1:0] lane_sel(input logic bhe_n, input logic a0);
    return {~bhe_n, ~a0};
  endfunction
endpackage

// File: rtl/mb_addr_latch.sv
module mb_addr_latch
  import membus_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ale,
  input  logic [15:0] ad_in,
  input  logic [3:0]  a_hi,
  input  logic        bhe_n,
  input  logic        mio,
  output bus_tag_t    tag
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tag <= '0;
    end else if (ale) begin
      tag <= '{addr: {a_hi, ad_in}, bhe_n: bhe_n, mio: mio};
    end
  end

  // R1
  tag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ale |=> $stable(tag));
endmodule

// File: rtl/mb_wait_gen.sv
module mb_wait_gen #(
  parameter int unsigned WAITS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd,
  output logic ready
);
  localparam int unsigned CNT_W = $clog2(WAITS + 2);

  logic [CNT_W-1:0] cnt;
  logic             cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      cmd_q <= 1'b0;
      ready <= 1'b1;
    end else begin
      cmd_q <= cmd;
      if (cmd && !cmd_q) begin
        cnt   <= CNT_W'(WAITS);
        ready <= (WAITS == 0);
      end else if (cnt > 1) begin
        cnt   <= cnt - 1'b1;
        ready <= 1'b0;
      end else begin
        cnt   <= '0;
        ready <= 1'b1;
      end
    end
  end

  // R10
  wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WAITS));
  // R10
  busy_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt != 0) |-> !ready);
endmodule

// File: rtl/mb_byte_bank.sv
module mb_byte_bank #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
    rdata <= mem[idx];
  end
endmodule

// File: rtl/membus_responder.sv
module membus_responder
  import membus_pkg::*;
#(
  parameter int unsigned BASE_ADDR = 32'h00400,
  parameter int unsigned WIN_BYTES = 512,
  parameter int unsigned WAITS     = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ale,
  input  logic [15:0] ad_in,
  input  logic [3:0]  a_hi,
  input  logic        bhe_n,
  input  logic        mio,
  input  logic        rd_n,
  input  logic        wr_n,
  output logic [15:0] ad_out,
  output logic [1:0]  ad_oe,
  output logic        ready
);
  localparam int unsigned DEPTH = WIN_BYTES / 2;
  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam logic [ADDR_W:0] LO_LIM = (ADDR_W+1)'(BASE_ADDR);
  localparam logic [ADDR_W:0] HI_LIM = (ADDR_W+1)'(BASE_ADDR + WIN_BYTES);

  bus_tag_t          tag;
  logic [ADDR_W-1:0] off;
  logic [IDX_W-1:0]  idx;
  logic [1:0]        lanes;
  logic              hit, rd_act, wr_act;
  logic [7:0]        rd_byte [2];
  logic [1:0]        oe_q;

  mb_addr_latch u_latch (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi),
    .bhe_n(bhe_n), .mio(mio), .tag(tag)
  );

  always_comb begin
    off    = tag.addr - ADDR_W'(BASE_ADDR);
    idx    = IDX_W'(off >> 1);
    lanes  = lane_sel(tag.bhe_n, tag.addr[0]);
    hit    = tag.mio && ({1'b0, tag.addr} >= LO_LIM) && ({1'b0, tag.addr} < HI_LIM);
    rd_act = hit && !rd_n;
    wr_act = hit && !wr_n;
  end

  for (genvar g = 0; g < 2; g++) begin : g_bank
    mb_byte_bank #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .we(wr_act && lanes[g]), .idx(idx),
      .wdata(ad_in[8*g +: 8]), .rdata(rd_byte[g])
    );
    assign ad_out[8*g +: 8] = oe_q[g] ? rd_byte[g] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 2'b00;
    else     oe_q <= rd_act ? lanes : 2'b00;
  end
  assign ad_oe = oe_q;

  mb_wait_gen #(.WAITS(WAITS)) u_wait (
    .clk(clk), .rst(rst), .cmd(rd_act || wr_act), .ready(ready)
  );

  // R9
  io_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ad_oe != 2'b00) |-> $past(tag.mio));
  // R6
  oe_needs_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (ad_oe != 2'b00) |-> $past(!rd_n));
  // R5
  none_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(tag.bhe_n && tag.addr[0]) |-> (ad_oe == 2'b00));
endmodule

// File: tb/tb_membus_responder.sv
module tb_membus_responder;
  localparam int BASE = 32'h00400;
  localparam int WIN  = 512;
  localparam int W    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ale = 1'b0, bhe_n = 1'b1, mio = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [15:0] ad_in = '0;
  logic [3:0]  a_hi = '0;
  logic [15:0] ad_out, ad_out0;
  logic [1:0]  ad_oe, ad_oe0;
  logic        ready, ready0;

  always #5 clk = ~clk;

  membus_responder #(.BASE_ADDR(BASE), .WIN_BYTES(WIN), .WAITS(W)) dut (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi), .bhe_n(bhe_n),
    .mio(mio), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe), .ready(ready));

  membus_responder #(.BASE_ADDR(BASE), .WIN_BYTES(WIN), .WAITS(0)) dut0 (
    .clk(clk), .rst(rst), .ale(ale), .ad_in(ad_in), .a_hi(a_hi), .bhe_n(bhe_n),
    .mio(mio), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out0), .ad_oe(ad_oe0), .ready(ready0));

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R11";

  // behavioural reference
  logic [7:0] ref_mem [int];
  int   m_addr = 0;
  bit   m_bhe = 0, m_mio = 0, m_cmd = 0;
  int   age = 1000;
  bit   e_ready = 1;
  logic [1:0]  e_oe = 0;
  logic [15:0] e_dat = 0;

  function automatic logic [7:0] getb(int a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    bit hit, lo, hi, cmd;
    int nage;
    if (rst) begin
      m_addr = 0; m_bhe = 0; m_mio = 0; m_cmd = 0; age = 1000;
      e_ready = 1; e_oe = 0; e_dat = 0;
    end else begin
      hit = m_mio && (m_addr >= BASE) && (m_addr < BASE + WIN);
      lo  = (m_addr % 2) == 0;
      hi  = !m_bhe;
      cmd = hit && (!rd_n || !wr_n);
      nage = (cmd && !m_cmd) ? 0 : ((age < 1000) ? age + 1 : age);
      e_ready = !(nage < W);
      age = nage;
      m_cmd = cmd;
      if (hit && !rd_n) begin
        e_oe  = {hi, lo};
        e_dat = {hi ? getb(m_addr | 1) : 8'h00, lo ? getb(m_addr & ~1) : 8'h00};
      end else begin
        e_oe = 0; e_dat = 0;
      end
      if (hit && !wr_n) begin
        if (lo) ref_mem[m_addr & ~1] = ad_in[7:0];
        if (hi) ref_mem[m_addr | 1]  = ad_in[15:8];
      end
      if (ale) begin
        m_addr = {a_hi, ad_in}; m_bhe = bhe_n; m_mio = mio;
      end
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); #2;
    chk("ready", {15'd0, ready}, {15'd0, e_ready});
    chk("ad_oe", {14'd0, ad_oe}, {14'd0, e_oe});
    chk("ad_out", ad_out, e_dat);
    chk("ready(WAITS=0) R10", {15'd0, ready0}, 16'd1);
  endtask

  task automatic bus_cycle(int addr, bit bhe, bit m, bit wr, logic [15:0] data);
    ale = 1; ad_in = addr[15:0]; a_hi = addr[19:16]; bhe_n = bhe; mio = m;
    step();
    // R1: lines now carry data and upper bits change; latched address must hold
    ale = 0; ad_in = wr ? data : 16'h0; a_hi = 4'hA;
    if (wr) wr_n = 0; else rd_n = 0;
    repeat (W + 2) step();
    rd_n = 1; wr_n = 1;
    repeat (2) step();
  endtask

  initial begin
    repeat (3) step();                     // R11 reset state
    rst = 0;
    step();
    cur_req = "R3";  bus_cycle(32'h00400, 0, 1, 1, 16'hA55A);
    bus_cycle(32'h00402, 0, 1, 1, 16'h1234);
    cur_req = "R2";  bus_cycle(32'h005FE, 0, 1, 1, 16'hC3D4);   // top row of window
    cur_req = "R3";  bus_cycle(32'h00400, 0, 1, 0, 16'h0);
    bus_cycle(32'h00402, 0, 1, 0, 16'h0);
    cur_req = "R4";  bus_cycle(32'h00403, 0, 1, 1, 16'hBE77);   // high lane only
    cur_req = "R7";  bus_cycle(32'h00402, 0, 1, 0, 16'h0);      // expect BE34
    cur_req = "R5";  bus_cycle(32'h00400, 1, 1, 1, 16'h9911);   // low lane only
    cur_req = "R7";  bus_cycle(32'h00400, 0, 1, 0, 16'h0);      // expect A511
    cur_req = "R5";  bus_cycle(32'h00401, 1, 1, 1, 16'hFFFF);   // no lane
    bus_cycle(32'h00401, 1, 1, 0, 16'h0);                       // no drive
    bus_cycle(32'h00400, 0, 1, 0, 16'h0);
    cur_req = "R4";  bus_cycle(32'h00403, 0, 1, 0, 16'h0);      // ad_oe 10
    cur_req = "R6";  bus_cycle(32'h00402, 1, 1, 0, 16'h0);      // ad_oe 01
    cur_req = "R8";  bus_cycle(32'h00600, 0, 1, 1, 16'hDEAD);   // one past window
    bus_cycle(32'h003FE, 0, 1, 1, 16'hBEEF);                    // just below window
    bus_cycle(32'h003FE, 0, 1, 0, 16'h0);
    bus_cycle(32'h00400, 0, 1, 0, 16'h0);
    bus_cycle(32'h005FE, 0, 1, 0, 16'h0);
    cur_req = "R9";  bus_cycle(32'h00400, 0, 0, 1, 16'h0F0F);   // I/O write ignored
    bus_cycle(32'h00400, 0, 0, 0, 16'h0);
    bus_cycle(32'h00400, 0, 1, 0, 16'h0);
    cur_req = "R10"; bus_cycle(32'h00404, 0, 1, 1, 16'h5A5A);
    bus_cycle(32'h00404, 0, 1, 0, 16'h0);
    cur_req = "R11"; rst = 1; step(); step(); rst = 0; step();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule